// File: doc/BRIEF.md
# Hot-Swap Insertion Qualification Controller

This block decides when the pass switch of a hot-plugged card may be turned on and when it must be turned off. It takes digital comparator results from outside: two active-low seating contacts, a master enable, an under-voltage OK flag, an over-voltage OK flag and a drain-sense OK flag. It also takes a trip request from the circuit breaker. It drives a gate-enable request for the switch driver, a power-good permit for the downstream converter sequencer and a supply-window fault flag.

Start-up begins only after every start condition has held without a break for a qualification window. The window length is a clock-cycle count picked from four parameters by a configuration field. After the gate is on, leaving the supply window has one of two outcomes. Without the filter option the gate is dropped at once. With the filter option the gate stays on until the excursion has lasted a filter time, and then a fault is latched that only the reset input clears. The active-low reset also forces every output off for as long as it is held low.

Top module: `insertion_qual`

## Requirements
- R1: When the seating contacts (if used), the master enable, uvOk, ovOk and the absence of cbFault are all true at N consecutive rising edges, gateEn goes high right after the Nth of those edges and not earlier. N is the selected qualification count.
- R2: If any start condition is false at one edge during qualification, the count restarts from zero. A full N further consecutive qualifying edges are then needed.
- R3: With cfgPdEn=1 both pd1N and pd2N must be 0 to qualify. With cfgPdEn=0 the values of pd1N and pd2N have no effect on gateEn or pgPermit.
- R4: cfgDelaySel selects N. Code 0 (the default) gives QUAL_CYC0, code 1 gives QUAL_CYC1, code 2 gives QUAL_CYC2 and code 3 gives QUAL_CYC3.
- R5: With cfgFiltEn=0, if uvOk or ovOk is 0 at an edge while gateEn is high, gateEn and pgPermit are low right after that edge, and uvovFault stays 0.
- R6: With cfgFiltEn=1, an excursion out of the supply window that lasts fewer than FILT_CYC consecutive edges leaves gateEn high. An excursion lasting FILT_CYC consecutive edges sets uvovFault and clears gateEn and pgPermit right after the last of those edges. The outputs stay in that state, even after the window is restored, until rstN is taken low.
- R7: While gateEn is high, losing a seating contact (with cfgPdEn=1) or masterEn at an edge clears gateEn and pgPermit right after that edge. The same happens if drainOk is 0 at an edge while pgPermit is high. A fresh qualification window is then needed.
- R8: If cbFault is 1 at an edge, gateEn and pgPermit are low right after that edge. No qualification progress is made while cbFault stays high.
- R9: While rstN is low, gateEn, pgPermit and uvovFault are all 0.
- R10: pgPermit goes high right after the first edge at which gateEn is high and drainOk is 1. pgPermit is never high while gateEn is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixed-frequency timing clock |
| rstN | input | 1 | Active-low reset, asynchronous; also clears a latched fault |
| pd1N | input | 1 | First seating contact, low when mated |
| pd2N | input | 1 | Second seating contact, low when mated |
| masterEn | input | 1 | Master enable, high to allow power |
| uvOk | input | 1 | Supply is above the under-voltage level |
| ovOk | input | 1 | Supply is below the over-voltage level |
| drainOk | input | 1 | Switch drain voltage is low (switch fully on) |
| cbFault | input | 1 | Trip request from the circuit breaker |
| cfgPdEn | input | 1 | 1: seating contacts take part in qualification |
| cfgDelaySel | input | 2 | Qualification count select, code 0 is the default |
| cfgFiltEn | input | 1 | 1: filter supply-window excursions and latch a fault |
| gateEn | output | 1 | Request to turn the pass switch on |
| pgPermit | output | 1 | Permit for downstream power-good sequencing |
| uvovFault | output | 1 | Latched supply-window fault |

## Verification
The in-line properties check these rules on every cycle. A gate-enable rise must follow a cycle in which all start conditions held. The gate must not stay on across a sampled master-enable loss or breaker trip, or across an unfiltered window excursion. Power-good must never be high without the gate. A latched fault must keep both permits off. The exact length of the qualification window, the restart after a single-cycle glitch, the effect of each delay code and the filter's short-versus-long excursion boundary can only be shown by the bench. Its scenarios are checked against a behavioural model cycle by cycle.

// File: rtl/hsq_pkg.sv
package hsq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RAMP  = 2'd1,
    ST_ON    = 2'd2,
    ST_FAULT = 2'd3
  } hsqState_t;

  typedef struct packed {
    logic qualInc;
    logic qualClr;
    logic filtInc;
    logic filtClr;
  } hsqStrobe_t;
endpackage

// File: rtl/hsq_timers.sv
module hsq_timers
  import hsq_pkg::*;
#(
  parameter int QUAL_CYC0 = 100000,
  parameter int QUAL_CYC1 = 20000,
  parameter int QUAL_CYC2 = 400000,
  parameter int QUAL_CYC3 = 800000,
  parameter int FILT_CYC  = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  hsqStrobe_t strb,
  input  logic [1:0] cfgDelaySel,
  output logic       qualDone,
  output logic       filtDone
);
  localparam int QMAX01 = (QUAL_CYC0 > QUAL_CYC1) ? QUAL_CYC0 : QUAL_CYC1;
  localparam int QMAX23 = (QUAL_CYC2 > QUAL_CYC3) ? QUAL_CYC2 : QUAL_CYC3;
  localparam int QMAX   = (QMAX01 > QMAX23) ? QMAX01 : QMAX23;
  localparam int QW     = $clog2(QMAX + 1);
  localparam int FW     = $clog2(FILT_CYC + 1);

  logic [QW-1:0] qualLim;
  logic [QW-1:0] qualCnt;
  logic [FW-1:0] filtCnt;

  always_comb begin
    case (cfgDelaySel)
      2'd1:    qualLim = QW'(QUAL_CYC1);
      2'd2:    qualLim = QW'(QUAL_CYC2);
      2'd3:    qualLim = QW'(QUAL_CYC3);
      default: qualLim = QW'(QUAL_CYC0);
    endcase
  end

  assign qualDone = (qualCnt >= qualLim - QW'(1));
  assign filtDone = (filtCnt >= FW'(FILT_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualCnt <= '0;
    end else if (strb.qualClr || (strb.qualInc && qualDone)) begin
      qualCnt <= '0;
    end else if (strb.qualInc) begin
      qualCnt <= qualCnt + QW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtCnt <= '0;
    end else if (strb.filtClr || (strb.filtInc && filtDone)) begin
      filtCnt <= '0;
    end else if (strb.filtInc) begin
      filtCnt <= filtCnt + FW'(1);
    end
  end

  // R2
  qual_cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    qualCnt < QW'(QMAX));

  // R6
  filt_cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    filtCnt < FW'(FILT_CYC));
endmodule

// File: rtl/hsq_ctrl.sv
module hsq_ctrl
  import hsq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pd1N,
  input  logic       pd2N,
  input  logic       masterEn,
  input  logic       uvOk,
  input  logic       ovOk,
  input  logic       drainOk,
  input  logic       cbFault,
  input  logic       cfgPdEn,
  input  logic       cfgFiltEn,
  input  logic       qualDone,
  input  logic       filtDone,
  output hsqStrobe_t strb,
  output logic       gateEn,
  output logic       pgPermit,
  output logic       uvovFault
);
  hsqState_t state, stateNxt;
  logic pdOk, runOk, inWindow, startOk;

  assign pdOk     = !cfgPdEn || (!pd1N && !pd2N);
  assign runOk    = pdOk && masterEn && !cbFault;
  assign inWindow = uvOk && ovOk;
  assign startOk  = runOk && inWindow;

  always_comb begin
    stateNxt     = state;
    strb.qualInc = 1'b0;
    strb.qualClr = 1'b1;
    strb.filtInc = 1'b0;
    case (state)
      ST_IDLE: begin
        strb.qualInc = startOk;
        strb.qualClr = !startOk;
        if (startOk && qualDone) stateNxt = ST_RAMP;
      end
      ST_RAMP, ST_ON: begin
        if (!runOk) begin
          stateNxt = ST_IDLE;
        end else if (state == ST_ON && !drainOk) begin
          stateNxt = ST_IDLE;
        end else if (!inWindow) begin
          if (!cfgFiltEn) begin
            stateNxt = ST_IDLE;
          end else begin
            strb.filtInc = 1'b1;
            if (filtDone) stateNxt = ST_FAULT;
          end
        end else if (state == ST_RAMP && drainOk) begin
          stateNxt = ST_ON;
        end
      end
      default: stateNxt = ST_FAULT;
    endcase
    strb.filtClr = !strb.filtInc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign gateEn    = (state == ST_RAMP) || (state == ST_ON);
  assign pgPermit  = (state == ST_ON);
  assign uvovFault = (state == ST_FAULT);

  // R1
  gate_rise_qualified_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateEn) |-> $past(masterEn && uvOk && ovOk && !cbFault &&
                            (!cfgPdEn || (!pd1N && !pd2N))));

  // R8
  gate_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateEn |-> $past(masterEn && !cbFault));

  // R5
  unfiltered_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!(uvOk && ovOk)) && $past(!cfgFiltEn)) |-> !gateEn);

  // R10
  pg_needs_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgPermit |-> gateEn);

  // R6
  fault_blocks_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    uvovFault |-> (!gateEn && !pgPermit));

  // R6
  fault_needs_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uvovFault) |-> $past(cfgFiltEn));
endmodule

// File: rtl/insertion_qual.sv
module insertion_qual
  import hsq_pkg::*;
#(
  parameter int QUAL_CYC0 = 100000,
  parameter int QUAL_CYC1 = 20000,
  parameter int QUAL_CYC2 = 400000,
  parameter int QUAL_CYC3 = 800000,
  parameter int FILT_CYC  = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pd1N,
  input  logic       pd2N,
  input  logic       masterEn,
  input  logic       uvOk,
  input  logic       ovOk,
  input  logic       drainOk,
  input  logic       cbFault,
  input  logic       cfgPdEn,
  input  logic [1:0] cfgDelaySel,
  input  logic       cfgFiltEn,
  output logic       gateEn,
  output logic       pgPermit,
  output logic       uvovFault
);
  hsqStrobe_t strb;
  logic qualDone, filtDone;

  hsq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .pd1N(pd1N), .pd2N(pd2N), .masterEn(masterEn),
    .uvOk(uvOk), .ovOk(ovOk), .drainOk(drainOk), .cbFault(cbFault),
    .cfgPdEn(cfgPdEn), .cfgFiltEn(cfgFiltEn), .qualDone(qualDone),
    .filtDone(filtDone), .strb(strb), .gateEn(gateEn), .pgPermit(pgPermit),
    .uvovFault(uvovFault)
  );

  hsq_timers #(
    .QUAL_CYC0(QUAL_CYC0), .QUAL_CYC1(QUAL_CYC1), .QUAL_CYC2(QUAL_CYC2),
    .QUAL_CYC3(QUAL_CYC3), .FILT_CYC(FILT_CYC)
  ) i_timers (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgDelaySel(cfgDelaySel),
    .qualDone(qualDone), .filtDone(filtDone)
  );
endmodule

// File: tb/test_insertion_qual.sv
`timescale 1ns/1ps
module test_insertion_qual;
  localparam int Q0 = 8, Q1 = 4, Q2 = 12, Q3 = 16, FC = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pd1N = 1'b1, pd2N = 1'b1, masterEn = 1'b0, uvOk = 1'b0, ovOk = 1'b0;
  logic drainOk = 1'b0, cbFault = 1'b0, cfgPdEn = 1'b1, cfgFiltEn = 1'b0;
  logic [1:0] cfgDelaySel = 2'd0;
  logic gateEn, pgPermit, uvovFault;

  int checks = 0, failures = 0;
  string curReq = "R9";
  bit finished = 0;

  always #2.5 clk = ~clk;

  insertion_qual #(.QUAL_CYC0(Q0), .QUAL_CYC1(Q1), .QUAL_CYC2(Q2),
                   .QUAL_CYC3(Q3), .FILT_CYC(FC)) i_insertion_qual (
    .clk(clk), .rstN(rstN), .pd1N(pd1N), .pd2N(pd2N), .masterEn(masterEn),
    .uvOk(uvOk), .ovOk(ovOk), .drainOk(drainOk), .cbFault(cbFault),
    .cfgPdEn(cfgPdEn), .cfgDelaySel(cfgDelaySel), .cfgFiltEn(cfgFiltEn),
    .gateEn(gateEn), .pgPermit(pgPermit), .uvovFault(uvovFault)
  );

  // behavioural reference: 0 off, 1 ramping, 2 on, 3 latched fault
  int mode = 0, qc = 0, fc = 0;
  wire mPd    = !cfgPdEn || (!pd1N && !pd2N);
  wire mRun   = mPd && masterEn && !cbFault;
  wire mWin   = uvOk && ovOk;
  wire mStart = mRun && mWin;

  function automatic int limOf(input logic [1:0] s);
    case (s)
      2'd1: return Q1;
      2'd2: return Q2;
      2'd3: return Q3;
      default: return Q0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode = 0; qc = 0; fc = 0;
    end else begin
      if (mode == 0) begin
        if (mStart) begin
          qc++;
          if (qc >= limOf(cfgDelaySel)) begin mode = 1; qc = 0; end
        end else qc = 0;
      end else if (mode == 1 || mode == 2) begin
        qc = 0;
        if (!mRun || (mode == 2 && !drainOk)) begin mode = 0; fc = 0; end
        else if (!mWin) begin
          if (!cfgFiltEn) begin mode = 0; fc = 0; end
          else begin
            fc++;
            if (fc >= FC) begin mode = 3; fc = 0; end
          end
        end else begin
          fc = 0;
          if (mode == 1 && drainOk) mode = 2;
        end
      end
    end
  end

  task automatic chk(input string req, input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!finished) begin
      chk(curReq, "gateEn", gateEn, (mode == 1 || mode == 2));
      chk(curReq, "pgPermit", pgPermit, (mode == 2));
      chk(curReq, "uvovFault", uvovFault, (mode == 3));
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic allGood();
    pd1N = 0; pd2N = 0; masterEn = 1; uvOk = 1; ovOk = 1; cbFault = 0;
  endtask

  task automatic allOff();
    pd1N = 1; pd2N = 1; masterEn = 0; uvOk = 0; ovOk = 0; drainOk = 0; cbFault = 0;
  endtask

  task automatic doReset();
    rstN = 0; tick(2); rstN = 1; tick(1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(1);
    curReq = "R9";
    chk("R9", "gateEn in reset", gateEn, 1'b0);
    chk("R9", "pgPermit in reset", pgPermit, 1'b0);
    chk("R9", "uvovFault in reset", uvovFault, 1'b0);
    rstN = 1; tick(2);

    // R1: exact qualification length with default code 0
    curReq = "R1";
    allGood(); tick(Q0 - 1);
    chk("R1", "gateEn before window", gateEn, 1'b0);
    tick(1);
    chk("R1", "gateEn after window", gateEn, 1'b1);
    // R10: power-good after drain ok
    curReq = "R10";
    chk("R10", "pgPermit before drain", pgPermit, 1'b0);
    drainOk = 1; tick(1);
    chk("R10", "pgPermit after drain", pgPermit, 1'b1);
    tick(3);

    // R7: master enable loss, then drain loss
    curReq = "R7";
    masterEn = 0; tick(1);
    chk("R7", "gateEn after enable loss", gateEn, 1'b0);
    masterEn = 1; tick(Q0 + 3);
    drainOk = 0; tick(1);
    chk("R7", "gateEn after drain loss", gateEn, 1'b0);
    drainOk = 1; tick(Q0 + 2);
    pd2N = 1; tick(2); pd2N = 0; tick(Q0 + 2);

    // R2: single-cycle glitch restarts the window
    curReq = "R2";
    allOff(); tick(3);
    allGood(); drainOk = 1; tick(5);
    pd1N = 1; tick(1); pd1N = 0;
    tick(Q0 - 1);
    chk("R2", "gateEn one short of restarted window", gateEn, 1'b0);
    tick(1);
    chk("R2", "gateEn after restarted window", gateEn, 1'b1);
    tick(2);

    // R3: seating contacts ignored when not used
    curReq = "R3";
    allOff(); tick(3);
    cfgPdEn = 0; allGood(); pd1N = 1; pd2N = 1; drainOk = 1;
    tick(Q0 + 2);
    chk("R3", "gateEn with contacts open, unused", gateEn, 1'b1);
    pd1N = 0; tick(2); pd2N = 0; pd1N = 1; tick(2);
    chk("R3", "pgPermit contacts toggling, unused", pgPermit, 1'b1);
    cfgPdEn = 1; pd1N = 1; tick(1);
    chk("R3", "gateEn contacts open, used", gateEn, 1'b0);
    tick(3);

    // R4: delay codes
    curReq = "R4";
    allOff(); tick(2);
    cfgDelaySel = 2'd1; allGood(); tick(Q1);
    chk("R4", "gateEn code1", gateEn, 1'b1);
    allOff(); tick(2);
    cfgDelaySel = 2'd3; allGood(); tick(Q3 - 1);
    chk("R4", "gateEn code3 early", gateEn, 1'b0);
    tick(1);
    chk("R4", "gateEn code3", gateEn, 1'b1);
    allOff(); tick(2);
    cfgDelaySel = 2'd2; allGood(); tick(Q2 + 1);
    cfgDelaySel = 2'd0;

    // R5: unfiltered excursion
    curReq = "R5";
    allOff(); tick(2); allGood(); drainOk = 1; tick(Q0 + 2);
    ovOk = 0; tick(1);
    chk("R5", "gateEn after ov excursion", gateEn, 1'b0);
    chk("R5", "uvovFault unfiltered", uvovFault, 1'b0);
    ovOk = 1; tick(Q0 + 2);

    // R6: filtered excursion, short then long
    curReq = "R6";
    cfgFiltEn = 1;
    uvOk = 0; tick(FC - 1); uvOk = 1; tick(1);
    chk("R6", "gateEn after short excursion", gateEn, 1'b1);
    tick(2);
    uvOk = 0; tick(FC - 1);
    chk("R6", "gateEn one before filter end", gateEn, 1'b1);
    tick(1);
    chk("R6", "uvovFault after long excursion", uvovFault, 1'b1);
    uvOk = 1; tick(Q0 + 4);
    chk("R6", "fault held after window restored", uvovFault, 1'b1);
    chk("R6", "gateEn held off by fault", gateEn, 1'b0);
    curReq = "R9";
    doReset();
    chk("R9", "fault cleared by reset", uvovFault, 1'b0);
    cfgFiltEn = 0;
    tick(Q0 + 2);

    // R8: breaker trip
    curReq = "R8";
    cbFault = 1; tick(1);
    chk("R8", "gateEn after trip", gateEn, 1'b0);
    tick(Q0 + 3);
    chk("R8", "gateEn held during trip", gateEn, 1'b0);
    cbFault = 0; tick(Q0 + 2);

    // R9: reset during on
    curReq = "R9";
    rstN = 0; tick(1);
    chk("R9", "gateEn under reset", gateEn, 1'b0);
    chk("R9", "pgPermit under reset", pgPermit, 1'b0);
    rstN = 1; tick(Q0 + 3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule